// File: doc/BRIEF.md
# Dual-Issue Slot Resource Reserver

This block sits at the issue point of a two-wide in-order integer core. Each cycle it receives up to two decoded instructions. The first is the older one in program order and the second is the younger one. Each instruction carries a class code and, for block transfers, a register count. The block decides which of the two may issue, which of the two issue slots each occupies, and which of the two integer pipes executes it.

Instruction classes are tied to particular slots and pipes. Some classes take both slots in one cycle. Several classes keep a pipe's execute stage busy for more than one cycle. For a transfer of several registers, that time depends on the register count. For multiply and multiply-accumulate it depends on a configuration input. For each pipe the block keeps a shift-register reservation table of future execute-stage cycles. It grants an instruction only when the chosen slot is free and the execute stage of the chosen pipe is free for the whole hold time.

Issue is strictly in order. The older instruction is considered first. The younger one issues only in the same cycle as the older one, never ahead of it. Grants, slot and pipe choices are registered, so they appear on the outputs one cycle after the request.

Top module: `dual_issue_reserver`

## Requirements
- R1: While `rst` is high at a clock edge, the table is cleared and all outputs are zero after that edge. An instruction requested in the first cycle after release sees both pipes free.
- R2: Class codes: 0 plain ALU/misc, 1 shift-combined ALU, 2 absolute-difference sum, 3 double move, 4 single load/store, 5 two-slot load/store, 6 multi-register transfer, 7 multiply, 8 multiply-accumulate, 9 divide, 10 divide-remainder, 11 pipe-0 single, 12 pipe-0 two-slot, and 13..15 act as 0. Classes 3, 4 and 6 may use only slot 1. Classes 7, 9 and 11 may use only slot 0. Classes 4, 5 and 6 run only in pipe 1, and classes 7..12 run only in pipe 0. Classes 0..3 may run in either pipe.
- R3: Classes 5, 8, 10 and 12 take both slots (`o_slot_used` = 2'b11, `o_slot[0]` = 0), and no younger instruction is granted in that cycle. A younger instruction of such a class is never granted beside an older one.
- R4: An older instruction that may use either slot takes slot 1 when the younger request is valid, single-slot and slot-0-only. Otherwise it takes slot 0.
- R5: An older instruction that may run in either pipe prefers pipe 1 when the younger request is valid, single-slot and pipe-0-tied. Otherwise it prefers pipe 0. If the preferred pipe is busy and the other is free, it takes the other.
- R6: When both instructions are granted, they occupy different slots and different pipes. The younger one takes the slot and pipe the older one left.
- R7: The younger instruction is granted only if the older one is granted in the same cycle.
- R8: The execute-stage hold is 2 cycles for class 1, 3 for class 2, 4 for classes 9 and 10, and 1 for classes 0, 3, 4, 5, 11 and 12.
- R9: Class 6 holds pipe 1 for its register count clamped to the range 1..4. A count of 0 counts as 1.
- R10: Classes 7 and 8 hold pipe 0 for 1 cycle when `i_mul_cfg` is 0, for 2 cycles when it is 1, and for 4 cycles when it is 2 or 3.
- R11: A pipe's execute stage is never reserved twice for one cycle. A request for a pipe reserved with hold L in cycle t is granted no earlier than cycle t+L, and it is granted in cycle t+L if it is still requested.
- R12: Grants, pipe and slot choices appear on the outputs one clock after the request. They do not change combinationally with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_req_vld | input | 2 | Request valid, bit 0 older, bit 1 younger |
| i_cls0 | input | 4 | Class code of the older instruction |
| i_cnt0 | input | CNT_W | Register count of the older instruction (class 6) |
| i_cls1 | input | 4 | Class code of the younger instruction |
| i_cnt1 | input | CNT_W | Register count of the younger instruction (class 6) |
| i_mul_cfg | input | 2 | Multiplier speed setting |
| o_gnt | output | 2 | Grant per instruction, bit 0 older |
| o_pipe | output | 2 | Pipe taken per instruction (0 when not granted) |
| o_slot | output | 2 | Slot taken per instruction (0 when not granted) |
| o_slot_used | output | 2 | Issue slots occupied this cycle |

## Verification
Several rules are checked on every cycle by the assertions. Each reservation table must stay a contiguous run from the current cycle, and no commit may overlap a reservation. A granted instruction must sit in a legal slot and in its bound pipe, must follow the in-order grant rule, and two granted instructions must have distinct slots and pipes. Outputs must stay quiet after a reset edge. Other rules can only be shown by the bench's scenarios: the exact hold length of every class, register count and multiplier setting, the older instruction's slot and pipe preference for each of the 169 class pairs, and the fallback to the other pipe when one is busy.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  localparam int HOLD_W    = 3;
  localparam int MAX_HOLD  = 4;
  localparam int SHIFT_HOLD = 2;
  localparam int SAD_HOLD  = 3;
  localparam int DIV_HOLD  = 4;
  localparam int MULTI_CAP = 4;
  localparam int MUL_F1_HOLD = 1;
  localparam int MUL_F2_HOLD = 2;
  localparam int MUL_SL_HOLD = 4;

  typedef enum logic [3:0] {
    CL_ALU       = 4'd0,
    CL_SHIFT     = 4'd1,
    CL_SAD       = 4'd2,
    CL_DMOVE     = 4'd3,
    CL_MEM       = 4'd4,
    CL_MEM_WIDE  = 4'd5,
    CL_MEM_MULTI = 4'd6,
    CL_MUL       = 4'd7,
    CL_MAC       = 4'd8,
    CL_DIV       = 4'd9,
    CL_DIVREM    = 4'd10,
    CL_P0        = 4'd11,
    CL_P0_WIDE   = 4'd12
  } iclass_e;

  typedef struct packed {
    logic              s0_ok;
    logic              s1_ok;
    logic              wide;
    logic              pipe_any;
    logic              pipe_fix;
    logic [HOLD_W-1:0] hold;
  } idec_t;

endpackage

// File: rtl/dsr_class_decode.sv
module dsr_class_decode
  import dsr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [3:0]       cls,
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       mul_cfg,
  output idec_t            dec
);

  logic [HOLD_W-1:0] multi_hold;
  logic [HOLD_W-1:0] mul_hold;

  always_comb begin
    if (cnt == '0)
      multi_hold = HOLD_W'(1);
    else if (cnt > CNT_W'(MULTI_CAP))
      multi_hold = HOLD_W'(MULTI_CAP);
    else
      multi_hold = HOLD_W'(cnt);
  end

  always_comb begin
    case (mul_cfg)
      2'd0:    mul_hold = HOLD_W'(MUL_F1_HOLD);
      2'd1:    mul_hold = HOLD_W'(MUL_F2_HOLD);
      default: mul_hold = HOLD_W'(MUL_SL_HOLD);
    endcase
  end

  always_comb begin
    dec          = '0;
    dec.s0_ok    = 1'b1;
    dec.s1_ok    = 1'b1;
    dec.pipe_any = 1'b1;
    dec.hold     = HOLD_W'(1);
    case (cls)
      CL_SHIFT: dec.hold = HOLD_W'(SHIFT_HOLD);
      CL_SAD:   dec.hold = HOLD_W'(SAD_HOLD);
      CL_DMOVE: dec.s0_ok = 1'b0;
      CL_MEM: begin
        dec.s0_ok    = 1'b0;
        dec.pipe_any = 1'b0;
        dec.pipe_fix = 1'b1;
      end
      CL_MEM_WIDE: begin
        dec.wide     = 1'b1;
        dec.pipe_any = 1'b0;
        dec.pipe_fix = 1'b1;
      end
      CL_MEM_MULTI: begin
        dec.s0_ok    = 1'b0;
        dec.pipe_any = 1'b0;
        dec.pipe_fix = 1'b1;
        dec.hold     = multi_hold;
      end
      CL_MUL: begin
        dec.s1_ok    = 1'b0;
        dec.pipe_any = 1'b0;
        dec.hold     = mul_hold;
      end
      CL_MAC: begin
        dec.wide     = 1'b1;
        dec.pipe_any = 1'b0;
        dec.hold     = mul_hold;
      end
      CL_DIV: begin
        dec.s1_ok    = 1'b0;
        dec.pipe_any = 1'b0;
        dec.hold     = HOLD_W'(DIV_HOLD);
      end
      CL_DIVREM: begin
        dec.wide     = 1'b1;
        dec.pipe_any = 1'b0;
        dec.hold     = HOLD_W'(DIV_HOLD);
      end
      CL_P0: begin
        dec.s1_ok    = 1'b0;
        dec.pipe_any = 1'b0;
      end
      CL_P0_WIDE: begin
        dec.wide     = 1'b1;
        dec.pipe_any = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dsr_ex_table.sv
module dsr_ex_table
  import dsr_pkg::*;
#(
  parameter int DEPTH = MAX_HOLD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HOLD_W-1:0] q0_hold,
  input  logic [HOLD_W-1:0] q1_hold,
  output logic [1:0]        fit,
  input  logic              commit,
  input  logic [HOLD_W-1:0] commit_hold
);

  // bit i set: execute stage busy i cycles from now
  logic [DEPTH-1:0] res_q;
  logic [DEPTH-1:0] ahead;

  function automatic logic [DEPTH-1:0] span(input logic [HOLD_W-1:0] len);
    logic [DEPTH-1:0] m;
    for (int i = 0; i < DEPTH; i++) m[i] = (i < int'(len));
    return m;
  endfunction

  assign ahead  = res_q >> 1;
  assign fit[0] = ~|(ahead & span(q0_hold));
  assign fit[1] = ~|(ahead & span(q1_hold));

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= ahead | (commit ? span(commit_hold) : '0);
  end

  // R11
  no_double_book_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> ((res_q >> 1) & span(commit_hold)) == '0);

  // R11
  resv_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({1'b0, res_q} + {{DEPTH{1'b0}}, 1'b1}) == 1);

endmodule

// File: rtl/dsr_issue_arbiter.sv
module dsr_issue_arbiter
  import dsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        req_vld,
  input  idec_t             dec0,
  input  idec_t             dec1,
  input  logic [1:0]        fit_p0,
  input  logic [1:0]        fit_p1,
  output logic [1:0]        grant,
  output logic [1:0]        pipe_sel,
  output logic [1:0]        slot_sel,
  output logic [1:0]        slot_used,
  output logic [1:0]        commit,
  output logic [HOLD_W-1:0] hold_p0,
  output logic [HOLD_W-1:0] hold_p1
);

  logic yng_s0_only, yng_p0_tied;
  logic old_slot, old_pref, old_pipe, old_ok, fit_pref, fit_alt;
  logic yng_slot, yng_pipe, yng_slot_ok, yng_pipe_ok;

  always_comb begin
    yng_s0_only = req_vld[1] & ~dec1.wide & ~dec1.s1_ok;
    yng_p0_tied = req_vld[1] & ~dec1.wide & ~dec1.pipe_any & ~dec1.pipe_fix;

    if (dec0.wide)                    old_slot = 1'b0;
    else if (dec0.s0_ok & dec0.s1_ok) old_slot = yng_s0_only;
    else                              old_slot = ~dec0.s0_ok;

    old_pref = dec0.pipe_any ? yng_p0_tied : dec0.pipe_fix;
    fit_pref = old_pref ? fit_p1[0] : fit_p0[0];
    fit_alt  = old_pref ? fit_p0[0] : fit_p1[0];
    old_pipe = old_pref;
    old_ok   = fit_pref;
    if (!fit_pref && dec0.pipe_any && fit_alt) begin
      old_pipe = ~old_pref;
      old_ok   = 1'b1;
    end
    grant[0] = ~rst & req_vld[0] & old_ok;

    yng_slot    = ~old_slot;
    yng_pipe    = ~old_pipe;
    yng_slot_ok = yng_slot ? dec1.s1_ok : dec1.s0_ok;
    yng_pipe_ok = (dec1.pipe_any | (dec1.pipe_fix == yng_pipe)) &
                  (yng_pipe ? fit_p1[1] : fit_p0[1]);
    grant[1] = grant[0] & req_vld[1] & ~dec0.wide & ~dec1.wide &
               yng_slot_ok & yng_pipe_ok;

    pipe_sel = {yng_pipe, old_pipe};
    slot_sel = {yng_slot, old_slot};

    slot_used = '0;
    if (grant[0]) begin
      if (dec0.wide) slot_used = 2'b11;
      else           slot_used[old_slot] = 1'b1;
    end
    if (grant[1]) slot_used[yng_slot] = 1'b1;

    commit[0] = (grant[0] & ~old_pipe) | (grant[1] & ~yng_pipe);
    commit[1] = (grant[0] &  old_pipe) | (grant[1] &  yng_pipe);
    hold_p0   = (grant[0] & ~old_pipe) ? dec0.hold : dec1.hold;
    hold_p1   = (grant[0] &  old_pipe) ? dec0.hold : dec1.hold;
  end

  // R2
  old_pipe_bind_chk: assert property (@(posedge clk) disable iff (rst)
    (grant[0] && !dec0.pipe_any) |-> pipe_sel[0] == dec0.pipe_fix);

  // R2
  yng_pipe_bind_chk: assert property (@(posedge clk) disable iff (rst)
    (grant[1] && !dec1.pipe_any) |-> pipe_sel[1] == dec1.pipe_fix);

  // R2
  old_slot_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (grant[0] && !dec0.wide) |-> (slot_sel[0] ? dec0.s1_ok : dec0.s0_ok));

  // R2
  yng_slot_legal_chk: assert property (@(posedge clk) disable iff (rst)
    grant[1] |-> (slot_sel[1] ? dec1.s1_ok : dec1.s0_ok));

endmodule

// File: rtl/dual_issue_reserver.sv
module dual_issue_reserver
  import dsr_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int DEPTH = MAX_HOLD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       i_req_vld,
  input  logic [3:0]       i_cls0,
  input  logic [CNT_W-1:0] i_cnt0,
  input  logic [3:0]       i_cls1,
  input  logic [CNT_W-1:0] i_cnt1,
  input  logic [1:0]       i_mul_cfg,
  output logic [1:0]       o_gnt,
  output logic [1:0]       o_pipe,
  output logic [1:0]       o_slot,
  output logic [1:0]       o_slot_used
);

  localparam int NUM_INS  = 2;
  localparam int NUM_PIPE = 2;

  logic [3:0]       cls_a [NUM_INS];
  logic [CNT_W-1:0] cnt_a [NUM_INS];
  idec_t            dec   [NUM_INS];
  logic [1:0]       fit   [NUM_PIPE];
  logic [1:0]       commit;
  logic [HOLD_W-1:0] commit_hold [NUM_PIPE];

  logic [1:0] grant, pipe_sel, slot_sel, slot_used;

  assign cls_a[0] = i_cls0;
  assign cls_a[1] = i_cls1;
  assign cnt_a[0] = i_cnt0;
  assign cnt_a[1] = i_cnt1;

  for (genvar gi = 0; gi < NUM_INS; gi++) begin : g_dec
    dsr_class_decode #(.CNT_W(CNT_W)) u_dec (
      .cls     (cls_a[gi]),
      .cnt     (cnt_a[gi]),
      .mul_cfg (i_mul_cfg),
      .dec     (dec[gi])
    );
  end

  for (genvar gp = 0; gp < NUM_PIPE; gp++) begin : g_tab
    dsr_ex_table #(.DEPTH(DEPTH)) u_tab (
      .clk         (clk),
      .rst         (rst),
      .q0_hold     (dec[0].hold),
      .q1_hold     (dec[1].hold),
      .fit         (fit[gp]),
      .commit      (commit[gp]),
      .commit_hold (commit_hold[gp])
    );
  end

  dsr_issue_arbiter u_arb (
    .clk       (clk),
    .rst       (rst),
    .req_vld   (i_req_vld),
    .dec0      (dec[0]),
    .dec1      (dec[1]),
    .fit_p0    (fit[0]),
    .fit_p1    (fit[1]),
    .grant     (grant),
    .pipe_sel  (pipe_sel),
    .slot_sel  (slot_sel),
    .slot_used (slot_used),
    .commit    (commit),
    .hold_p0   (commit_hold[0]),
    .hold_p1   (commit_hold[1])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      o_gnt       <= '0;
      o_pipe      <= '0;
      o_slot      <= '0;
      o_slot_used <= '0;
    end else begin
      o_gnt       <= grant;
      o_pipe      <= pipe_sel & grant;
      o_slot      <= slot_sel & grant;
      o_slot_used <= slot_used;
    end
  end

  logic rst_d_q;
  always_ff @(posedge clk) begin
    rst_d_q <= rst;
    // R1
    if (rst_d_q == 1'b1) reset_quiet_chk: assert (o_gnt == '0 && o_slot_used == '0);
  end

  // R7
  in_order_chk: assert property (@(posedge clk) disable iff (rst)
    o_gnt[1] |-> o_gnt[0]);

  // R6
  distinct_res_chk: assert property (@(posedge clk) disable iff (rst)
    o_gnt[1] |-> (o_pipe[0] != o_pipe[1] && o_slot[0] != o_slot[1] && o_slot_used == 2'b11));

  // R3
  slot_use_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (o_slot_used != 2'b00) |-> o_gnt[0]);

endmodule

// File: tb/dual_issue_reserver_tb.sv
module dual_issue_reserver_tb;

  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       i_req_vld = '0;
  logic [3:0]       i_cls0 = '0, i_cls1 = '0;
  logic [CNT_W-1:0] i_cnt0 = '0, i_cnt1 = '0;
  logic [1:0]       i_mul_cfg = '0;
  logic [1:0]       o_gnt, o_pipe, o_slot, o_slot_used;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dual_issue_reserver #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .i_req_vld(i_req_vld),
    .i_cls0(i_cls0), .i_cnt0(i_cnt0), .i_cls1(i_cls1), .i_cnt1(i_cnt1),
    .i_mul_cfg(i_mul_cfg), .o_gnt(o_gnt), .o_pipe(o_pipe),
    .o_slot(o_slot), .o_slot_used(o_slot_used)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [1:0] v, input int c0, input int c1,
                       input int n0, input int n1, input int cfg);
    i_req_vld = v;
    i_cls0 = 4'(c0);  i_cls1 = 4'(c1);
    i_cnt0 = CNT_W'(n0); i_cnt1 = CNT_W'(n1);
    i_mul_cfg = 2'(cfg);
  endtask

  task automatic drain();
    drive(2'b00, 0, 0, 0, 0, 0);
    repeat (5) tick();
  endtask

  // spec model
  function automatic int b_allow(input int c);
    if (c == 3 || c == 4 || c == 6) return 2;
    if (c == 7 || c == 9 || c == 11) return 1;
    return 3;
  endfunction
  function automatic bit b_wide(input int c);
    return (c == 5 || c == 8 || c == 10 || c == 12);
  endfunction
  function automatic int b_pipe(input int c);
    if (c <= 3) return -1;
    if (c <= 6) return 1;
    return 0;
  endfunction
  function automatic int b_hold(input int c, input int n, input int cfg);
    case (c)
      1: return 2;
      2: return 3;
      6: return (n == 0) ? 1 : ((n > 4) ? 4 : n);
      7, 8: return (cfg == 0) ? 1 : ((cfg == 1) ? 2 : 4);
      9, 10: return 4;
      default: return 1;
    endcase
  endfunction

  task automatic measure(input int c, input int n, input int cfg, input string tag);
    int exp_l, pp, probe, waited;
    exp_l = b_hold(c, n, cfg);
    pp = (b_pipe(c) < 0) ? 0 : b_pipe(c);
    probe = (pp == 0) ? 11 : 4;
    drive(2'b01, c, 0, n, 0, cfg);
    tick();
    chk(o_gnt == 2'b01, {tag, " first grant"}, o_gnt, 1);
    chk(o_pipe[0] == pp[0], {tag, " pipe"}, o_pipe[0], pp);
    drive(2'b01, probe, 0, 1, 0, cfg);
    waited = 0;
    for (int k = 0; k < 8; k++) begin
      tick();
      waited++;
      if (o_gnt[0]) break;
    end
    chk(waited == exp_l, {tag, " R11 hold length"}, waited, exp_l);
    drain();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: requests during reset are never granted
    drive(2'b11, 0, 0, 1, 1, 0);
    repeat (3) begin
      tick();
      chk(o_gnt == 2'b00, "R1 grant in reset", o_gnt, 0);
      chk(o_slot_used == 2'b00, "R1 slots in reset", o_slot_used, 0);
    end
    drive(2'b00, 0, 0, 0, 0, 0);
    tick();
    rst = 1'b0;
    tick();
    chk(o_gnt == 2'b00, "R1 idle after release", o_gnt, 0);

    // R12: output does not follow the request combinationally
    drive(2'b01, 0, 0, 1, 0, 0);
    #2;
    chk(o_gnt == 2'b00, "R12 before edge", o_gnt, 0);
    tick();
    chk(o_gnt == 2'b01, "R12 after edge", o_gnt, 1);
    drain();

    // R2..R6: every class pair on idle pipes
    for (int a = 0; a < 13; a++) begin
      for (int b = 0; b < 13; b++) begin
        bit y0only, yp0, eg1;
        int es0, ep0, eused;
        y0only = !b_wide(b) && b_allow(b) == 1;
        yp0    = !b_wide(b) && b_pipe(b) == 0;
        if (b_wide(a))          es0 = 0;
        else if (b_allow(a) == 3) es0 = y0only;
        else                    es0 = (b_allow(a) == 2);
        ep0 = (b_pipe(a) < 0) ? int'(yp0) : b_pipe(a);
        eg1 = !b_wide(a) && !b_wide(b) && ((b_allow(b) >> (1 - es0)) & 1) &&
              (b_pipe(b) < 0 || b_pipe(b) == 1 - ep0);
        eused = b_wide(a) ? 3 : ((1 << es0) | (eg1 ? (1 << (1 - es0)) : 0));
        drive(2'b11, a, b, 1, 1, 0);
        tick();
        chk(o_gnt[0] == 1'b1, "R2 older grant", o_gnt[0], 1);
        chk(o_slot[0] == es0[0], "R4 older slot", o_slot[0], es0);
        chk(o_pipe[0] == ep0[0], "R5 older pipe", o_pipe[0], ep0);
        chk(o_gnt[1] == eg1, "R3 younger grant", o_gnt[1], eg1);
        chk(o_slot_used == 2'(eused), "R6 slot use", o_slot_used, eused);
        if (eg1) begin
          chk(o_pipe[1] != o_pipe[0], "R6 younger pipe", o_pipe[1], 1 - ep0);
          chk(o_slot[1] != o_slot[0], "R6 younger slot", o_slot[1], 1 - es0);
        end
        drain();
      end
    end

    // R8: fixed holds of every class
    for (int c = 0; c < 13; c++) measure(c, 1, 0, "R8");
    // R9: register count clamp
    for (int n = 0; n < 13; n++) measure(6, n, 0, "R9");
    // R10: multiplier speed setting
    for (int cfg = 0; cfg < 4; cfg++) begin
      measure(7, 1, cfg, "R10 mul");
      measure(8, 1, cfg, "R10 mac");
    end

    // R5: flexible instruction falls back to pipe 1 while pipe 0 is held
    drive(2'b01, 9, 0, 1, 0, 0);
    tick();
    drive(2'b01, 0, 0, 1, 0, 0);
    tick();
    chk(o_gnt == 2'b01, "R5 fallback grant", o_gnt, 1);
    chk(o_pipe[0] == 1'b1, "R5 fallback pipe", o_pipe[0], 1);
    drain();

    // R7: stalled older blocks a younger that could go
    drive(2'b01, 9, 0, 1, 0, 0);
    tick();
    drive(2'b11, 7, 0, 1, 1, 0);
    tick();
    chk(o_gnt == 2'b00, "R7 in-order stall", o_gnt, 0);
    drain();

    // R11: younger blocked by busy pipe 1, older proceeds
    drive(2'b01, 6, 0, 4, 0, 0);
    tick();
    drive(2'b11, 0, 0, 1, 1, 0);
    tick();
    chk(o_gnt == 2'b01, "R11 busy pipe 1", o_gnt, 1);
    chk(o_pipe[0] == 1'b0, "R11 older pipe", o_pipe[0], 0);
    drain();

    // R1: reset mid-run clears reservations
    drive(2'b01, 9, 0, 1, 0, 0);
    tick();
    chk(o_gnt == 2'b01, "R1 divide issued", o_gnt, 1);
    rst = 1'b1;
    drive(2'b01, 7, 0, 1, 0, 0);
    tick();
    chk(o_gnt == 2'b00, "R1 reset edge", o_gnt, 0);
    rst = 1'b0;
    tick();
    chk(o_gnt == 2'b01, "R1 table cleared", o_gnt, 1);
    drain();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule